// File: doc/BRIEF.md
# Data-Controller Transfer Start/Finish Sequencer

This block decides what happens when software triggers a transfer out of an optical-disc data controller. A one-cycle start strobe arrives with a 3-bit destination code and a byte count. Some codes are rejected outright. Some codes name the host read port; for these, the data is already waiting, so the block only raises a "data ready" flag. The remaining codes name DMA targets. For these, the block stays busy for a number of clock cycles derived from the byte count.

When a timed transfer runs out, the block does three things. It drops its busy status bit and pulls an active-low end-of-transfer flag low. It also emits a single-cycle interrupt request, but only when the interrupt enable input is high. The block computes the word length of each timed transfer. Its mode, status, interface-status and length values can be read through a small registered read port. The data movement itself is handled elsewhere.

Top module: `cdx_xfer_dispatch`

## Requirements
- R1: After reset, mode_o is 0x00, status_o is 0x00, ifstat_o is 0xFF, word_len_o is 0 and irq_o is low.
- R2: A start with destination code 0, 1 or 6 is ignored. mode_o, status_o, ifstat_o and word_len_o keep their values, a running timed transfer keeps its remaining duration, and no interrupt results.
- R3: A start with code 2 or 3 sets mode_o bit 6 (data ready) and writes the code into mode_o[2:0] on the clock edge that samples the strobe. It does not set the busy bit.
- R4: A start with code 4, 5 or 7 sets status_o bit 3 (busy), sets ifstat_o bit 6 high, clears mode_o bit 6 and writes the code into mode_o[2:0], all on the sampling edge.
- R5: A timed transfer started with byte count B stays busy for exactly D = max(1, floor(B/2)) clock cycles. Busy drops on the D-th edge after the sampling edge.
- R6: A timed start loads word_len_o with (B+1)>>1.
- R7: On completion, status_o bit 3 goes low and ifstat_o bit 6 goes low on the same edge.
- R8: irq_o is high for exactly one cycle, starting on the completion edge, if and only if irq_en_i was high in the cycle before that edge.
- R9: A timed start while busy restarts the duration from the new byte count. The earlier transfer produces no completion and no interrupt.
- R10: rd_data_o shows, one cycle after rd_sel_i is sampled, the following value: sel 0 gives mode_o, sel 1 gives status_o, sel 2 gives ifstat_o, sel 3 gives word_len_o[7:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle transfer start strobe |
| dest_i | input | 3 | Destination code sampled with start_i |
| byte_cnt_i | input | 16 | Transfer byte count sampled with start_i |
| irq_en_i | input | 1 | Interrupt enable for completion |
| rd_sel_i | input | 2 | Read port register select |
| mode_o | output | 8 | Mode: [2:0] last accepted code, [6] data ready |
| status_o | output | 8 | Status: [3] timed transfer busy |
| ifstat_o | output | 8 | Interface status: [6] end-of-transfer flag (active low); the other bits are 1 |
| word_len_o | output | 16 | Word length of the last timed transfer |
| irq_o | output | 1 | Completion interrupt pulse |
| rd_data_o | output | 8 | Registered read data |

## Verification
The bench targets the shortest durations: byte counts 0 and 1 must still give one busy cycle, not zero cycles and not a wrapped counter. It also runs a maximum count, where an off-by-one in the halving would show up as a wrong cycle total. A start that arrives while a transfer is running is tested two ways. A valid restart must reload the counter and produce exactly one interrupt. An invalid one must leave the running countdown and the word length alone; a design that decoded it as a start would shorten or extend the busy window. A completion with the enable low must end the transfer without an interrupt. A host-port start must raise the ready flag and must not set the busy bit.

// File: rtl/cdx_pkg.sv
package cdx_pkg;
  localparam int DEST_W = 3;

  localparam int MODE_READY_BIT = 6;
  localparam int STAT_BUSY_BIT  = 3;
  localparam int IFS_DONE_N_BIT = 6;

  typedef enum logic [1:0] {
    DK_NONE  = 2'd0,
    DK_HOST  = 2'd1,
    DK_TIMED = 2'd2
  } dest_kind_e;

  function automatic dest_kind_e classify_dest(input logic [DEST_W-1:0] code);
    dest_kind_e k;
    case (code)
      3'd2, 3'd3:       k = DK_HOST;
      3'd4, 3'd5, 3'd7: k = DK_TIMED;
      default:          k = DK_NONE;
    endcase
    return k;
  endfunction
endpackage

// File: rtl/cdx_dest_decode.sv
module cdx_dest_decode
  import cdx_pkg::*;
(
  input  logic              start_i,
  input  logic [DEST_W-1:0] dest_i,
  output logic              host_go_o,
  output logic              timed_go_o
);
  dest_kind_e kind;

  always_comb begin
    kind       = classify_dest(dest_i);
    host_go_o  = start_i && (kind == DK_HOST);
    timed_go_o = start_i && (kind == DK_TIMED);
  end
endmodule

// File: rtl/cdx_busy_timer.sv
module cdx_busy_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] byte_cnt_i,
  output logic             busy_o,
  output logic             fin_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] half;
  logic [CNT_W-1:0] dur;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  always_comb begin
    half = byte_cnt_i >> 1;
    dur  = (half == '0) ? ONE : half;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (load_i) begin
      cnt_q  <= dur;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (cnt_q == ONE) begin
        cnt_q  <= '0;
        busy_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q - ONE;
      end
    end
  end

  assign busy_o = busy_q;
  assign fin_o  = busy_q && (cnt_q == ONE) && !load_i;
endmodule

// File: rtl/cdx_status_regs.sv
module cdx_status_regs
  import cdx_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_go_i,
  input  logic              timed_go_i,
  input  logic [DEST_W-1:0] dest_i,
  input  logic [CNT_W-1:0]  byte_cnt_i,
  input  logic              busy_i,
  input  logic              fin_i,
  input  logic              irq_en_i,
  input  logic [1:0]        rd_sel_i,
  output logic [DATA_W-1:0] mode_o,
  output logic [DATA_W-1:0] status_o,
  output logic [DATA_W-1:0] ifstat_o,
  output logic [CNT_W-1:0]  word_len_o,
  output logic              irq_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [CNT_W:0]      wsum;
  logic [DEST_W-1:0]   code_q;
  logic                ready_q;
  logic                done_n_q;
  logic [CNT_W-1:0]    wlen_q;
  logic                irq_q;
  logic [DATA_W-1:0]   rd_q;
  logic [DATA_W-1:0]   mode_w;
  logic [DATA_W-1:0]   stat_w;
  logic [DATA_W-1:0]   ifs_w;

  assign wsum = {1'b0, byte_cnt_i} + (CNT_W+1)'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q   <= '0;
      ready_q  <= 1'b0;
      done_n_q <= 1'b1;
      wlen_q   <= '0;
      irq_q    <= 1'b0;
    end else begin
      irq_q <= fin_i && irq_en_i;
      if (fin_i)
        done_n_q <= 1'b0;
      if (host_go_i) begin
        code_q  <= dest_i;
        ready_q <= 1'b1;
      end else if (timed_go_i) begin
        code_q   <= dest_i;
        ready_q  <= 1'b0;
        done_n_q <= 1'b1;
        wlen_q   <= wsum[CNT_W:1];
      end
    end
  end

  always_comb begin
    mode_w = '0;
    mode_w[DEST_W-1:0]     = code_q;
    mode_w[MODE_READY_BIT] = ready_q;
    stat_w = '0;
    stat_w[STAT_BUSY_BIT]  = busy_i;
    ifs_w  = '1;
    ifs_w[IFS_DONE_N_BIT]  = done_n_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0;
    end else begin
      case (rd_sel_i)
        2'd0:    rd_q <= mode_w;
        2'd1:    rd_q <= stat_w;
        2'd2:    rd_q <= ifs_w;
        default: rd_q <= wlen_q[DATA_W-1:0];
      endcase
    end
  end

  assign mode_o     = mode_w;
  assign status_o   = stat_w;
  assign ifstat_o   = ifs_w;
  assign word_len_o = wlen_q;
  assign irq_o      = irq_q;
  assign rd_data_o  = rd_q;
endmodule

// File: rtl/cdx_xfer_dispatch.sv
module cdx_xfer_dispatch
  import cdx_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [2:0]        dest_i,
  input  logic [CNT_W-1:0]  byte_cnt_i,
  input  logic              irq_en_i,
  input  logic [1:0]        rd_sel_i,
  output logic [DATA_W-1:0] mode_o,
  output logic [DATA_W-1:0] status_o,
  output logic [DATA_W-1:0] ifstat_o,
  output logic [CNT_W-1:0]  word_len_o,
  output logic              irq_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic host_go;
  logic timed_go;
  logic busy;
  logic fin;

  cdx_dest_decode u_dec (
    .start_i    (start_i),
    .dest_i     (dest_i),
    .host_go_o  (host_go),
    .timed_go_o (timed_go)
  );

  cdx_busy_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk        (clk),
    .rst        (rst),
    .load_i     (timed_go),
    .byte_cnt_i (byte_cnt_i),
    .busy_o     (busy),
    .fin_o      (fin)
  );

  cdx_status_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .host_go_i  (host_go),
    .timed_go_i (timed_go),
    .dest_i     (dest_i),
    .byte_cnt_i (byte_cnt_i),
    .busy_i     (busy),
    .fin_i      (fin),
    .irq_en_i   (irq_en_i),
    .rd_sel_i   (rd_sel_i),
    .mode_o     (mode_o),
    .status_o   (status_o),
    .ifstat_o   (ifstat_o),
    .word_len_o (word_len_o),
    .irq_o      (irq_o),
    .rd_data_o  (rd_data_o)
  );
endmodule

// File: rtl/cdx_xfer_dispatch_chk.sv
module cdx_xfer_dispatch_chk #(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic [2:0]        dest_i,
  input logic              irq_en_i,
  input logic [DATA_W-1:0] mode_o,
  input logic [DATA_W-1:0] status_o,
  input logic [DATA_W-1:0] ifstat_o,
  input logic [CNT_W-1:0]  word_len_o,
  input logic              irq_o
);
  logic is_host, is_timed, is_bad;
  assign is_host  = start_i && (dest_i[2:1] == 2'b01);
  assign is_timed = start_i && dest_i[2] && (dest_i != 3'd6);
  assign is_bad   = start_i && !is_host && !is_timed;

  p_ignored_r2: assert property (@(posedge clk) disable iff (rst)
    is_bad |=> ($stable(mode_o) && $stable(word_len_o)));

  p_host_ready_r3: assert property (@(posedge clk) disable iff (rst)
    is_host |=> mode_o[6]);

  p_timed_busy_r4: assert property (@(posedge clk) disable iff (rst)
    is_timed |=> (status_o[3] && ifstat_o[6] && !mode_o[6]));

  p_done_flag_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(status_o[3]) |-> !ifstat_o[6]);

  p_irq_single_r8: assert property (@(posedge clk) disable iff (rst)
    irq_o |=> !irq_o);

  p_irq_cause_r8: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> ($fell(status_o[3]) && $past(irq_en_i)));
endmodule

bind cdx_xfer_dispatch cdx_xfer_dispatch_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start_i    (start_i),
  .dest_i     (dest_i),
  .irq_en_i   (irq_en_i),
  .mode_o     (mode_o),
  .status_o   (status_o),
  .ifstat_o   (ifstat_o),
  .word_len_o (word_len_o),
  .irq_o      (irq_o)
);

// File: tb/cdx_xfer_dispatch_tb.sv
`timescale 1ns/1ps
module cdx_xfer_dispatch_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [2:0]  dest_i = '0;
  logic [15:0] byte_cnt_i = '0;
  logic        irq_en_i = 1'b0;
  logic [1:0]  rd_sel_i = '0;
  logic [7:0]  mode_o, status_o, ifstat_o, rd_data_o;
  logic [15:0] word_len_o;
  logic        irq_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  cdx_xfer_dispatch u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .dest_i(dest_i),
    .byte_cnt_i(byte_cnt_i), .irq_en_i(irq_en_i), .rd_sel_i(rd_sel_i),
    .mode_o(mode_o), .status_o(status_o), .ifstat_o(ifstat_o),
    .word_len_o(word_len_o), .irq_o(irq_o), .rd_data_o(rd_data_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive a start at a negedge; return at the negedge after the sampling edge
  task automatic pulse_start(input logic [2:0] code, input logic [15:0] b);
    start_i = 1'b1; dest_i = code; byte_cnt_i = b;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // count busy observations from now, then irq pulses
  task automatic measure(output int busy_n, output int irq_n, output logic ifs6_end);
    busy_n = 0; irq_n = 0;
    while (status_o[3] && busy_n < 70000) begin
      busy_n++;
      irq_n += int'(irq_o);
      @(negedge clk);
    end
    ifs6_end = ifstat_o[6];
    irq_n += int'(irq_o);
    @(negedge clk);
    irq_n += int'(irq_o);
  endtask

  task automatic t_reset();
    chk("R1 mode", mode_o, 8'h00);
    chk("R1 status", status_o, 8'h00);
    chk("R1 ifstat", ifstat_o, 8'hFF);
    chk("R1 wlen", word_len_o, 0);
    chk("R1 irq", irq_o, 0);
  endtask

  task automatic t_host(input logic [2:0] code);
    pulse_start(code, 16'd50);
    chk("R3 mode", mode_o, 8'h40 | code);
    chk("R3 busy", status_o[3], 0);
  endtask

  task automatic t_invalid(input logic [2:0] code);
    logic [7:0] m, s, f; logic [15:0] w; int irqs = 0;
    m = mode_o; s = status_o; f = ifstat_o; w = word_len_o;
    pulse_start(code, 16'd200);
    for (int i = 0; i < 3; i++) begin irqs += int'(irq_o); @(negedge clk); end
    chk("R2 mode", mode_o, m);
    chk("R2 status", status_o, s);
    chk("R2 ifstat", ifstat_o, f);
    chk("R2 wlen", word_len_o, w);
    chk("R2 irq", irqs, 0);
  endtask

  task automatic t_timed(input logic [2:0] code, input logic [15:0] b, input logic en);
    int bn, in_; logic e6; int d;
    d = ((b >> 1) == 0) ? 1 : int'(b >> 1);
    irq_en_i = en;
    pulse_start(code, b);
    chk("R4 mode", mode_o, {5'b0, code});
    chk("R4 ifstat6", ifstat_o[6], 1);
    chk("R6 wlen", word_len_o, (32'(b) + 1) >> 1);
    measure(bn, in_, e6);
    chk("R5 duration", bn, d);
    chk("R7 ifstat6 low", e6, 0);
    chk("R8 irq count", in_, en ? 1 : 0);
  endtask

  task automatic t_restart();
    int bn, in_; logic e6; int early = 0;
    irq_en_i = 1'b1;
    pulse_start(3'd4, 16'd40);
    for (int i = 0; i < 4; i++) begin early += int'(irq_o); @(negedge clk); end
    pulse_start(3'd5, 16'd6);
    chk("R9 wlen", word_len_o, 16'd3);
    measure(bn, in_, e6);
    chk("R9 restarted duration", bn, 3);
    chk("R9 irq count", in_ + early, 1);
  endtask

  task automatic t_invalid_busy();
    int bn, in_; logic e6;
    irq_en_i = 1'b1;
    pulse_start(3'd4, 16'd20);
    @(negedge clk);
    pulse_start(3'd6, 16'd4);
    chk("R2 mode while busy", mode_o, 8'h04);
    chk("R2 wlen while busy", word_len_o, 16'd10);
    measure(bn, in_, e6);
    chk("R2 remaining duration", bn, 8);
    chk("R2 irq count", in_, 1);
  endtask

  task automatic t_read();
    irq_en_i = 1'b0;
    pulse_start(3'd7, 16'd9);  // busy 4 cycles, wlen 5
    rd_sel_i = 2'd1; @(negedge clk);
    chk("R10 status", rd_data_o, 8'h08);
    rd_sel_i = 2'd0; @(negedge clk);
    chk("R10 mode", rd_data_o, 8'h07);
    rd_sel_i = 2'd3; @(negedge clk);
    chk("R10 wlen", rd_data_o, 8'h05);
    repeat (3) @(negedge clk);
    rd_sel_i = 2'd2; @(negedge clk);
    chk("R10 ifstat", rd_data_o, 8'hBF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_host(3'd2);
    t_invalid(3'd0);
    t_invalid(3'd1);
    t_invalid(3'd6);
    t_host(3'd3);
    t_timed(3'd4, 16'd10, 1'b1);
    t_timed(3'd5, 16'd1, 1'b1);
    t_timed(3'd7, 16'd0, 1'b0);
    t_timed(3'd4, 16'd33, 1'b0);
    t_timed(3'd5, 16'hFFFF, 1'b1);
    t_restart();
    t_invalid_busy();
    t_read();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule